// File: doc/BRIEF.md
# Relative Branch and Subroutine Unit

This unit executes the control-flow opcodes of a small 16-bit virtual machine: the nine relative branches, a subroutine call, a subroutine return and a break request. On a one-cycle `start` pulse it captures a 4-bit opcode, the signed displacement byte, the address of the opcode, the carry flag, the value of the prior-result register and the stack-pointer register. When it finishes it returns the next program counter together with any stack-pointer update and any carry-clear request.

Branch conditions are tested against the carry, or against the 16-bit register that the machine's status pointer names as holding the last result. Calls and returns move the return address through a byte stack in memory. The stack pointer is an ordinary register that software can see. The memory port carries one byte per beat and uses a request/ready handshake.

Top module: `rel_branch_unit`

## Requirements
- R1: A taken branch sets `next_pc` to `pc + 2 + d`, where d is `disp` sign-extended (-128..+127), with 16-bit wraparound. A branch (opcodes 1..9) that is not taken sets `next_pc` to `pc + 2`.
- R2: Opcode 1 always branches. Opcode 2 branches only when `carry_in` is 0. Opcode 3 branches only when `carry_in` is 1.
- R3: Opcode 4 branches when bit 15 of `prior` is 0, and opcode 5 branches when it is 1. The other bits of `prior` have no effect on these two.
- R4: Opcode 6 branches when all 16 bits of `prior` are zero. Opcode 7 branches when any of them is one.
- R5: Opcode 8 branches only when `prior` is 0xFFFF. Opcode 9 branches only when it is not. A value with only one byte equal to 0xFF is not minus one.
- R6: Opcodes 1..9 and 10, 13, 14, 15 and 0 assert `done` in the first cycle after the `start` edge. They make no memory request and leave `carry_clr` and `r12_we` low.
- R7: Opcode 12 (call) writes the low byte of `pc + 2` to address `r12_in`, then writes the high byte to `r12_in + 1`. It then finishes with `next_pc` equal to the R1 target, `r12_out = r12_in + 2`, `r12_we` high and `carry_clr` high.
- R8: Opcode 11 (return) reads the high byte at `r12_in - 1`, then reads the low byte at `r12_in - 2`. It finishes with `next_pc` made from those two bytes, `r12_out = r12_in - 2`, `r12_we` high and `carry_clr` low.
- R9: Each stack byte takes exactly one memory beat, which completes on a clock edge where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, the request, direction, address and write data are held.
- R10: Opcode 10 raises `brk` in its `done` cycle with `next_pc = pc + 1`. Opcodes 0, 13, 14 and 15 give `next_pc = pc + 1` and raise nothing.
- R11: After reset, `done`, `brk`, `mem_req`, `r12_we` and `carry_clr` are low.
- R12: `brk`, `r12_we` and `carry_clr` are high only in a cycle where `done` is high. `mem_req` is never high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one opcode; accepted only when idle |
| op | input | 4 | Control-flow opcode |
| disp | input | 8 | Signed branch displacement |
| pc | input | 16 | Address of the opcode byte |
| carry_in | input | 1 | Current carry flag |
| prior | input | 16 | Value of the prior-result register |
| r12_in | input | 16 | Current stack-pointer register |
| done | output | 1 | One-cycle completion strobe |
| next_pc | output | 16 | Program counter to continue at |
| r12_we | output | 1 | Write `r12_out` into the stack pointer |
| r12_out | output | 16 | New stack-pointer value |
| carry_clr | output | 1 | Clear the carry flag |
| brk | output | 1 | Break request |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory beat completes at the next edge |

## Verification
Opcodes that do not use the stack give `done` one cycle after the edge that samples `start`. A call or a return with memory that never stalls gives `done` three cycles after that edge: two memory beats plus the finishing cycle. Each wait cycle that memory inserts adds exactly one cycle to that count. The bench drives `start` on a falling edge and then counts falling edges until it sees `done`. It compares that count with the expected latency, and it takes every result in that same `done` cycle. In the stalled runs, the bench counts the completed memory beats and checks the bytes they leave in memory.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam logic [3:0] OP_BR   = 4'h1;
  localparam logic [3:0] OP_BNC  = 4'h2;
  localparam logic [3:0] OP_BC   = 4'h3;
  localparam logic [3:0] OP_BP   = 4'h4;
  localparam logic [3:0] OP_BM   = 4'h5;
  localparam logic [3:0] OP_BZ   = 4'h6;
  localparam logic [3:0] OP_BNZ  = 4'h7;
  localparam logic [3:0] OP_BM1  = 4'h8;
  localparam logic [3:0] OP_BNM1 = 4'h9;
  localparam logic [3:0] OP_BRK  = 4'hA;
  localparam logic [3:0] OP_RET  = 4'hB;
  localparam logic [3:0] OP_CALL = 4'hC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_LO, ST_PUSH_HI, ST_POP_HI, ST_POP_LO, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/rbu_cond.sv
module rbu_cond
  import rbu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic         carry,
  input  logic [W-1:0] prior,
  output logic         take
);
  logic is_zero, is_ones, is_neg;

  always_comb begin
    is_zero = (prior == '0);
    is_ones = &prior;
    is_neg  = prior[W-1];
    case (op)
      OP_BR:   take = 1'b1;
      OP_BNC:  take = ~carry;
      OP_BC:   take = carry;
      OP_BP:   take = ~is_neg;
      OP_BM:   take = is_neg;
      OP_BZ:   take = is_zero;
      OP_BNZ:  take = ~is_zero;
      OP_BM1:  take = is_ones;
      OP_BNM1: take = ~is_ones;
      OP_CALL: take = 1'b1;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic [W-1:0]  pc,
  input  logic [DW-1:0] disp,
  output logic [W-1:0]  target,
  output logic [W-1:0]  pc_plus2,
  output logic [W-1:0]  pc_plus1
);
  logic [W-1:0] disp_sx;

  always_comb begin
    disp_sx  = {{(W-DW){disp[DW-1]}}, disp};
    pc_plus1 = pc + W'(1);
    pc_plus2 = pc + W'(2);
    target   = pc_plus2 + disp_sx;
  end
endmodule

// File: rtl/rbu_stack_seq.sv
module rbu_stack_seq
  import rbu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic          take,
  input  logic [W-1:0]  target,
  input  logic [W-1:0]  pc_plus2,
  input  logic [W-1:0]  pc_plus1,
  input  logic [W-1:0]  r12_in,
  output logic          done,
  output logic [W-1:0]  next_pc,
  output logic          r12_we,
  output logic [W-1:0]  r12_out,
  output logic          carry_clr,
  output logic          brk,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  input  logic          mem_ready
);
  seq_state_e    st_q, st_d;
  logic [W-1:0]  sp_q, sp_d;
  logic [W-1:0]  ret_q, ret_d;
  logic [W-1:0]  tgt_q, tgt_d;
  logic [W-1:0]  npc_q, npc_d;
  logic [BW-1:0] hi_q, hi_d;
  logic          clr_q, clr_d, brk_q, brk_d, wsp_q, wsp_d;
  logic          is_branch;

  always_comb begin
    st_d  = st_q;
    sp_d  = sp_q;
    ret_d = ret_q;
    tgt_d = tgt_q;
    npc_d = npc_q;
    hi_d  = hi_q;
    clr_d = clr_q;
    brk_d = brk_q;
    wsp_d = wsp_q;
    is_branch = (op >= OP_BR) && (op <= OP_BNM1);
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          clr_d = 1'b0;
          brk_d = 1'b0;
          wsp_d = 1'b0;
          sp_d  = r12_in;
          ret_d = pc_plus2;
          tgt_d = target;
          if (op == OP_CALL) begin
            st_d = ST_PUSH_LO;
          end else if (op == OP_RET) begin
            st_d = ST_POP_HI;
          end else begin
            st_d  = ST_DONE;
            brk_d = (op == OP_BRK);
            if (take)           npc_d = target;
            else if (is_branch) npc_d = pc_plus2;
            else                npc_d = pc_plus1;
          end
        end
      end
      ST_PUSH_LO: if (mem_ready) begin
        sp_d = sp_q + W'(1);
        st_d = ST_PUSH_HI;
      end
      ST_PUSH_HI: if (mem_ready) begin
        sp_d  = sp_q + W'(1);
        npc_d = tgt_q;
        clr_d = 1'b1;
        wsp_d = 1'b1;
        st_d  = ST_DONE;
      end
      ST_POP_HI: if (mem_ready) begin
        sp_d = sp_q - W'(1);
        hi_d = mem_rdata;
        st_d = ST_POP_LO;
      end
      ST_POP_LO: if (mem_ready) begin
        sp_d  = sp_q - W'(1);
        npc_d = {hi_q, mem_rdata};
        wsp_d = 1'b1;
        st_d  = ST_DONE;
      end
      default: begin
        clr_d = 1'b0;
        brk_d = 1'b0;
        wsp_d = 1'b0;
        st_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sp_q  <= '0;
      ret_q <= '0;
      tgt_q <= '0;
      npc_q <= '0;
      hi_q  <= '0;
      clr_q <= 1'b0;
      brk_q <= 1'b0;
      wsp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sp_q  <= sp_d;
      ret_q <= ret_d;
      tgt_q <= tgt_d;
      npc_q <= npc_d;
      hi_q  <= hi_d;
      clr_q <= clr_d;
      brk_q <= brk_d;
      wsp_q <= wsp_d;
    end
  end

  always_comb begin
    done      = (st_q == ST_DONE);
    next_pc   = npc_q;
    r12_out   = sp_q;
    r12_we    = done & wsp_q;
    carry_clr = done & clr_q;
    brk       = done & brk_q;
    mem_req   = (st_q == ST_PUSH_LO) || (st_q == ST_PUSH_HI) ||
                (st_q == ST_POP_HI)  || (st_q == ST_POP_LO);
    mem_we    = (st_q == ST_PUSH_LO) || (st_q == ST_PUSH_HI);
    mem_addr  = mem_we ? sp_q : (sp_q - W'(1));
    mem_wdata = (st_q == ST_PUSH_HI) ? ret_q[W-1:BW] : ret_q[BW-1:0];
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit #(
  parameter int W  = 16,
  parameter int DW = 8,
  localparam int BW = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [DW-1:0] disp,
  input  logic [W-1:0]  pc,
  input  logic          carry_in,
  input  logic [W-1:0]  prior,
  input  logic [W-1:0]  r12_in,
  output logic          done,
  output logic [W-1:0]  next_pc,
  output logic          r12_we,
  output logic [W-1:0]  r12_out,
  output logic          carry_clr,
  output logic          brk,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  input  logic          mem_ready
);
  logic         take;
  logic [W-1:0] target, pc_plus2, pc_plus1;

  rbu_cond #(.W(W)) u_cond (
    .op(op), .carry(carry_in), .prior(prior), .take(take)
  );

  rbu_target #(.W(W), .DW(DW)) u_tgt (
    .pc(pc), .disp(disp), .target(target),
    .pc_plus2(pc_plus2), .pc_plus1(pc_plus1)
  );

  rbu_stack_seq #(.W(W), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .take(take),
    .target(target), .pc_plus2(pc_plus2), .pc_plus1(pc_plus1),
    .r12_in(r12_in), .done(done), .next_pc(next_pc), .r12_we(r12_we),
    .r12_out(r12_out), .carry_clr(carry_clr), .brk(brk),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );
endmodule

// File: rtl/rbu_chk.sv
module rbu_chk #(
  parameter int W  = 16,
  parameter int BW = W / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    op,
  input logic          done,
  input logic          r12_we,
  input logic          carry_clr,
  input logic          brk,
  input logic          mem_req,
  input logic          mem_we,
  input logic [W-1:0]  mem_addr,
  input logic [BW-1:0] mem_wdata,
  input logic          mem_ready
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             busy_q <= 1'b0;
    else if (done)          busy_q <= 1'b0;
    else if (start)         busy_q <= 1'b1;
  end

  // R6
  simple_op_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && op != 4'hB && op != 4'hC) |=> (done && !mem_req));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R12
  done_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R12
  side_effects_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk || r12_we || carry_clr) |-> done);

  // R11
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mem_req && !brk && !r12_we && !carry_clr));
endmodule

bind rel_branch_unit rbu_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .done(done),
  .r12_we(r12_we), .carry_clr(carry_clr), .brk(brk), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/tb_rel_branch_unit.sv
module tb_rel_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, carry_in;
  logic [3:0]  op;
  logic [7:0]  disp, mem_wdata, mem_rdata;
  logic [15:0] pc, prior, r12_in, next_pc, r12_out, mem_addr;
  logic        done, r12_we, carry_clr, brk, mem_req, mem_we, mem_ready;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [0:255];
  logic stall_en, tog;
  int beats;

  logic [15:0] s_pc, s_r12;
  logic s_we, s_clr, s_brk;
  int lat;

  rel_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .disp(disp), .pc(pc),
    .carry_in(carry_in), .prior(prior), .r12_in(r12_in), .done(done),
    .next_pc(next_pc), .r12_we(r12_we), .r12_out(r12_out),
    .carry_clr(carry_clr), .brk(brk), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ready = mem_req && (!stall_en || tog);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
    if (mem_req && mem_ready) begin
      beats <= beats + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] d, input logic [15:0] p,
                        input logic c, input logic [15:0] pr, input logic [15:0] sp);
    @(negedge clk);
    op = o; disp = d; pc = p; carry_in = c; prior = pr; r12_in = sp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op = 4'h0; disp = 8'h00; pc = 16'h0; prior = 16'h0; r12_in = 16'h0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    s_pc = next_pc; s_r12 = r12_out; s_we = r12_we; s_clr = carry_clr; s_brk = brk;
  endtask

  task automatic branch_case(input string req, input logic [3:0] o, input logic c,
                             input logic [15:0] pr, input logic taken);
    logic [15:0] p;
    p = 16'h2000;
    run_op(o, 8'hF0, p, c, pr, 16'h0);
    check({req, " next_pc"}, s_pc, taken ? 16'h1FF2 : 16'h2002);
  endtask

  task automatic t_reset();
    check("R11 done", {15'b0, done}, 16'h0);
    check("R11 side", {11'b0, brk, mem_req, r12_we, carry_clr, 1'b0}, 16'h0);
  endtask

  task automatic t_target();
    run_op(4'h1, 8'h50, 16'h0300, 1'b0, 16'h0, 16'h0);
    check("R1 fwd", s_pc, 16'h0352);
    run_op(4'h1, 8'h80, 16'h0300, 1'b0, 16'h0, 16'h0);
    check("R1 back", s_pc, 16'h0282);
    run_op(4'h1, 8'h20, 16'hFFF0, 1'b0, 16'h0, 16'h0);
    check("R1 wrap", s_pc, 16'h0012);
    check("R6 latency", 16'(lat), 16'd1);
    check("R6 no side", {13'b0, s_we, s_clr, s_brk}, 16'h0);
  endtask

  task automatic t_conds();
    branch_case("R2 bnc c0", 4'h2, 1'b0, 16'h0, 1'b1);
    branch_case("R2 bnc c1", 4'h2, 1'b1, 16'h0, 1'b0);
    branch_case("R2 bc c1",  4'h3, 1'b1, 16'h0, 1'b1);
    branch_case("R2 bc c0",  4'h3, 1'b0, 16'h0, 1'b0);
    branch_case("R3 bp pos", 4'h4, 1'b0, 16'h7FFF, 1'b1);
    branch_case("R3 bp neg", 4'h4, 1'b0, 16'h8000, 1'b0);
    branch_case("R3 bm neg", 4'h5, 1'b0, 16'h8000, 1'b1);
    branch_case("R3 bm lowff", 4'h5, 1'b0, 16'h00FF, 1'b0);
    branch_case("R4 bz zero", 4'h6, 1'b1, 16'h0000, 1'b1);
    branch_case("R4 bz hi", 4'h6, 1'b0, 16'h0100, 1'b0);
    branch_case("R4 bnz hi", 4'h7, 1'b0, 16'h0100, 1'b1);
    branch_case("R4 bnz zero", 4'h7, 1'b0, 16'h0000, 1'b0);
    branch_case("R5 bm1 ffff", 4'h8, 1'b0, 16'hFFFF, 1'b1);
    branch_case("R5 bm1 ff00", 4'h8, 1'b0, 16'hFF00, 1'b0);
    branch_case("R5 bnm1 00ff", 4'h9, 1'b0, 16'h00FF, 1'b1);
    branch_case("R5 bnm1 ffff", 4'h9, 1'b0, 16'hFFFF, 1'b0);
    check("R6 no side", {13'b0, s_we, s_clr, s_brk}, 16'h0);
  endtask

  task automatic t_brk_nop();
    run_op(4'hA, 8'h10, 16'h0500, 1'b0, 16'h0, 16'h0);
    check("R10 brk", {15'b0, s_brk}, 16'h1);
    check("R10 brk pc", s_pc, 16'h0501);
    for (int k = 13; k <= 15; k++) begin
      run_op(4'(k), 8'h10, 16'h0600, 1'b1, 16'h0, 16'h0);
      check("R10 nop pc", s_pc, 16'h0601);
      check("R10 nop side", {13'b0, s_we, s_clr, s_brk}, 16'h0);
    end
    run_op(4'h0, 8'h10, 16'h0700, 1'b0, 16'h0, 16'h0);
    check("R10 op0 pc", s_pc, 16'h0701);
    check("R6 op0 lat", 16'(lat), 16'd1);
  endtask

  task automatic t_call_ret(input logic stall, input logic [15:0] sp);
    stall_en = stall;
    beats = 0;
    run_op(4'hC, 8'h10, 16'h1234, 1'b1, 16'h0, sp);
    check("R7 target", s_pc, 16'h1246);
    check("R7 r12", s_r12, sp + 16'd2);
    check("R7 flags", {14'b0, s_we, s_clr}, 16'h3);
    check("R7 mem lo", {8'h0, mem[sp[7:0]]}, 16'h0036);
    check("R7 mem hi", {8'h0, mem[sp[7:0] + 8'd1]}, 16'h0012);
    if (!stall) check("R9 call lat", 16'(lat), 16'd3);
    check("R9 call beats", 16'(beats), 16'd2);
    beats = 0;
    run_op(4'hB, 8'h00, 16'h7777, 1'b0, 16'h0, sp + 16'd2);
    check("R8 ret pc", s_pc, 16'h1236);
    check("R8 r12", s_r12, sp);
    check("R8 flags", {14'b0, s_we, s_clr}, 16'h2);
    if (!stall) check("R9 ret lat", 16'(lat), 16'd3);
    check("R9 ret beats", 16'(beats), 16'd2);
    stall_en = 1'b0;
  endtask

  task automatic t_ret_order();
    mem[8'h81] = 8'hBE;
    mem[8'h80] = 8'hEF;
    run_op(4'hB, 8'h00, 16'h0, 1'b0, 16'h0, 16'h0082);
    check("R8 byte order", s_pc, 16'hBEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; start = 1'b0; op = 4'h0; disp = 8'h0; pc = 16'h0;
    carry_in = 1'b0; prior = 16'h0; r12_in = 16'h0; stall_en = 1'b0; beats = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_target();
    t_conds();
    t_brk_nop();
    t_call_ret(1'b0, 16'h0040);
    t_call_ret(1'b1, 16'h0060);
    t_ret_order();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule